// File: doc/BRIEF.md
# Shared Counting Semaphore Cell

This block is one inter-requester communication cell configured as a counting semaphore. Up to eight requesters share it. Each request carries an access-view code, a read/write flag, a 3-bit requester number and a data word. The cell keeps a 16-bit count. A read through one of the two semaphore views takes one unit, and a write through either of them gives one unit back. The same cell can also be reached through a raw view that shows the count and through a control view that exposes three tag flags.

A read through the waiting semaphore view on a zero count does not complete. The cell answers "blocked" and notes the requester in a waiter mask. The next give-back empties that mask and sends one pulse on the wake outputs, listing every requester that was parked, so that logic outside the block can schedule their retries. A read through the try semaphore view never parks.

There is one request per cycle at most. Every request gets a registered response one clock later.

Top module: `sem_cell`

## Requirements
- R1: After reset the count, the three tag flags (T, F, E) and the waiter mask are zero, and `rsp_valid_o` and `wake_valid_o` are low.
- R2: Every request accepted on an edge with `req_valid_i` high produces `rsp_valid_o` high for exactly the cycle after that edge.
- R3: A read with view code 4 (waiting) or 5 (try) on a nonzero count returns the count as it was before the access, zero-extended, and lowers the count by one.
- R4: A read with view code 4 on a zero count responds with `rsp_blocked_o` high and data 0, sets bit `req_id_i` of the waiter mask, and leaves the count unchanged.
- R5: A read with view code 5 on a zero count returns 0 with `rsp_blocked_o` low and changes neither the count nor the waiter mask.
- R6: A write with view code 4 or 5 raises the count by one and holds it at 0xFFFF once it reaches 0xFFFF. The write data has no effect.
- R7: A write with view code 4 or 5 clears the waiter mask. If the mask was nonzero, `wake_valid_o` is high for one cycle, in the same cycle as that write's response, and `wake_mask_o` carries the mask that was cleared. Otherwise there is no wake pulse.
- R8: A read with view code 0 returns the count, zero-extended, and does not change it. A write with view code 0 changes nothing.
- R9: A read with view code 2 or 3 returns 0. A write with either code changes nothing.
- R10: A read with view code 1 returns T in bit 16, F in bit 1 and E in bit 0, with bit 17 (the FIFO-mode flag) and every other bit 0. A write with view code 1 loads T, F and E from data bits 16, 1 and 0 and leaves the count unchanged.
- R11: A read with any view code from 6 to 15 returns 0. A write with any of those codes changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_view_i | input | 4 | Access-view code |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_id_i | input | 3 | Requester number |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_blocked_o | output | 1 | Requester was parked, not served |
| rsp_rdata_o | output | 32 | Read data (0 for writes) |
| wake_valid_o | output | 1 | One-cycle release pulse |
| wake_mask_o | output | 8 | Requesters released by the pulse |
| waiters_o | output | 8 | Current waiter mask |

## Verification
Releasing waiters and parking a new requester can follow each other with no gap. A give-back drives the wake pulse in the same cycle as its response. A waiting take issued right after it is then served from the freshly released unit, and a second waiting take re-parks at once. The bench provokes this in three ways: with directed back-to-back give-back and take sequences, with a count that stays pinned at 0xFFFF, and with long runs of mixed random traffic. At each response cycle it compares the response, the wake pulse, its mask and the live waiter mask against a reference model.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

   // view codes decoded from the request
   localparam int unsigned VIEW_RAW      = 0;
   localparam int unsigned VIEW_CTRL     = 1;
   localparam int unsigned VIEW_QUE_WAIT = 2;
   localparam int unsigned VIEW_QUE_TRY  = 3;
   localparam int unsigned VIEW_SEM_WAIT = 4;
   localparam int unsigned VIEW_SEM_TRY  = 5;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_TAKE_WAIT,
      OP_TAKE_TRY,
      OP_GIVE,
      OP_RAW_RD,
      OP_CTL_RD,
      OP_CTL_WR,
      OP_NULL
   } sem_op_e;

endpackage

// File: rtl/sem_decode.sv
module sem_decode
   import sem_cell_pkg::*;
#(
   parameter int unsigned VIEW_W = 4
) (
   input  logic              valid_i,
   input  logic [VIEW_W-1:0] view_i,
   input  logic              write_i,
   output sem_op_e           op_o
);

   initial begin
      if (VIEW_W < 3) $error("sem_decode: VIEW_W must hold code 5");
   end

   always_comb begin
      op_o = OP_NONE;
      if (valid_i) begin
         if (view_i == VIEW_W'(VIEW_SEM_WAIT))
            op_o = write_i ? OP_GIVE : OP_TAKE_WAIT;
         else if (view_i == VIEW_W'(VIEW_SEM_TRY))
            op_o = write_i ? OP_GIVE : OP_TAKE_TRY;
         else if (view_i == VIEW_W'(VIEW_RAW))
            op_o = write_i ? OP_NULL : OP_RAW_RD;
         else if (view_i == VIEW_W'(VIEW_CTRL))
            op_o = write_i ? OP_CTL_WR : OP_CTL_RD;
         else
            op_o = OP_NULL;   // queue views and unknown codes
      end
   end

endmodule

// File: rtl/sem_counter.sv
module sem_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial begin
      if (CNT_W < 2 || CNT_W > 32) $error("sem_counter: CNT_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_inc;
      else if (dec_i) cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i |-> cnt_q != '0);

   assert_take_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !inc_i) |=> cnt_q == $past(cnt_q) - 1'b1);

   generate
      if (SATURATE) begin : g_sat_chk
         assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
      end
   endgenerate

endmodule

// File: rtl/sem_waiters.sv
module sem_waiters #(
   parameter int unsigned ID_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 park_i,
   input  logic [ID_W-1:0]      park_id_i,
   input  logic                 release_i,
   output logic [(1<<ID_W)-1:0] mask_o,
   output logic                 wake_valid_o,
   output logic [(1<<ID_W)-1:0] wake_mask_o
);

   localparam int unsigned NREQ = 1 << ID_W;

   initial begin
      if (ID_W < 1 || ID_W > 6) $error("sem_waiters: ID_W out of range");
   end

   logic [NREQ-1:0] mask_q;
   logic [NREQ-1:0] wake_mask_q;
   logic            wake_valid_q;

   generate
      for (genvar i = 0; i < NREQ; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       mask_q[i] <= 1'b0;
            else if (release_i)                               mask_q[i] <= 1'b0;
            else if (park_i && park_id_i == ID_W'(i))         mask_q[i] <= 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_valid_q <= 1'b0;
         wake_mask_q  <= '0;
      end else begin
         wake_valid_q <= release_i && (mask_q != '0);
         wake_mask_q  <= release_i ? mask_q : '0;
      end
   end

   assign mask_o       = mask_q;
   assign wake_valid_o = wake_valid_q;
   assign wake_mask_o  = wake_mask_q;

   assert_wake_carries_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && mask_q != '0) |=> wake_valid_o && wake_mask_o == $past(mask_q) && mask_q == '0);

   assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid_o |=> !wake_valid_o);

   assert_park_sets_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (park_i && !release_i) |=> mask_q[$past(park_id_i)]);

endmodule

// File: rtl/sem_tag_reg.sv
module sem_tag_reg #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned T_POS    = 16,
   parameter int unsigned F_POS    = 1,
   parameter int unsigned E_POS    = 0,
   parameter int unsigned MODE_POS = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] word_o
);

   initial begin
      if (T_POS >= DATA_W || F_POS >= DATA_W || E_POS >= DATA_W || MODE_POS >= DATA_W)
         $error("sem_tag_reg: flag position outside data word");
   end

   logic t_q, f_q, e_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q <= 1'b0;
         f_q <= 1'b0;
         e_q <= 1'b0;
      end else if (wr_i) begin
         t_q <= wdata_i[T_POS];
         f_q <= wdata_i[F_POS];
         e_q <= wdata_i[E_POS];
      end
   end

   always_comb begin
      word_o           = '0;
      word_o[T_POS]    = t_q;
      word_o[F_POS]    = f_q;
      word_o[E_POS]    = e_q;
      word_o[MODE_POS] = 1'b0;   // semaphore cell, never queue mode
   end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_cell_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned ID_W     = 3,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned VIEW_W   = 4,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid_i,
   input  logic [VIEW_W-1:0]    req_view_i,
   input  logic                 req_write_i,
   input  logic [ID_W-1:0]      req_id_i,
   input  logic [DATA_W-1:0]    req_wdata_i,
   output logic                 rsp_valid_o,
   output logic                 rsp_blocked_o,
   output logic [DATA_W-1:0]    rsp_rdata_o,
   output logic                 wake_valid_o,
   output logic [(1<<ID_W)-1:0] wake_mask_o,
   output logic [(1<<ID_W)-1:0] waiters_o
);

   localparam int unsigned NREQ     = 1 << ID_W;
   localparam int unsigned T_POS    = 16;
   localparam int unsigned MODE_POS = 17;

   initial begin
      if (DATA_W <= MODE_POS) $error("sem_cell: DATA_W too narrow for tag word");
      if (DATA_W < CNT_W)     $error("sem_cell: DATA_W narrower than count");
   end

   sem_op_e          op;
   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;
   logic             take, give, park;
   logic [DATA_W-1:0] tag_word;
   logic [DATA_W-1:0] rdata_d;
   logic [NREQ-1:0]   waiters;

   sem_decode #(.VIEW_W(VIEW_W)) u_dec (
      .valid_i (req_valid_i),
      .view_i  (req_view_i),
      .write_i (req_write_i),
      .op_o    (op)
   );

   assign take = (op == OP_TAKE_WAIT || op == OP_TAKE_TRY) && !cnt_zero;
   assign give = (op == OP_GIVE);
   assign park = (op == OP_TAKE_WAIT) && cnt_zero;

   sem_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (give),
      .dec_i  (take),
      .cnt_o  (cnt),
      .zero_o (cnt_zero)
   );

   sem_waiters #(.ID_W(ID_W)) u_wait (
      .clk          (clk),
      .rst_n        (rst_n),
      .park_i       (park),
      .park_id_i    (req_id_i),
      .release_i    (give),
      .mask_o       (waiters),
      .wake_valid_o (wake_valid_o),
      .wake_mask_o  (wake_mask_o)
   );

   sem_tag_reg #(
      .DATA_W   (DATA_W),
      .T_POS    (T_POS),
      .F_POS    (1),
      .E_POS    (0),
      .MODE_POS (MODE_POS)
   ) u_tag (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (op == OP_CTL_WR),
      .wdata_i (req_wdata_i),
      .word_o  (tag_word)
   );

   always_comb begin
      unique case (op)
         OP_TAKE_WAIT,
         OP_TAKE_TRY,
         OP_RAW_RD:  rdata_d = DATA_W'(cnt);   // zero count yields 0
         OP_CTL_RD:  rdata_d = tag_word;
         default:    rdata_d = '0;
      endcase
   end

   logic              rsp_valid_q, rsp_blocked_q;
   logic [DATA_W-1:0] rsp_rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q   <= 1'b0;
         rsp_blocked_q <= 1'b0;
         rsp_rdata_q   <= '0;
      end else begin
         rsp_valid_q   <= req_valid_i;
         rsp_blocked_q <= park;
         rsp_rdata_q   <= rdata_d;
      end
   end

   assign rsp_valid_o   = rsp_valid_q;
   assign rsp_blocked_o = rsp_blocked_q;
   assign rsp_rdata_o   = rsp_rdata_q;
   assign waiters_o     = waiters;

   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> rsp_valid_o);

   assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> !rsp_valid_o);

   assert_blocked_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && rsp_blocked_o) |-> (waiters_o != '0 && rsp_rdata_o == '0));

   assert_mode_flag_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && $past(op == OP_CTL_RD)) |-> !rsp_rdata_o[MODE_POS]);

endmodule

// File: tb/sem_cell_tb.sv
module sem_cell_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_view = '0;
   logic        req_write = 1'b0;
   logic [2:0]  req_id = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_blocked, wake_valid;
   logic [31:0] rsp_rdata;
   logic [7:0]  wake_mask, waiters;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   // reference model state
   int unsigned m_cnt = 0;
   bit          m_t = 0, m_f = 0, m_e = 0;
   logic [7:0]  m_wait = '0;

   always #10 clk = ~clk;   // 50 MHz

   sem_cell dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid_i   (req_valid),
      .req_view_i    (req_view),
      .req_write_i   (req_write),
      .req_id_i      (req_id),
      .req_wdata_i   (req_wdata),
      .rsp_valid_o   (rsp_valid),
      .rsp_blocked_o (rsp_blocked),
      .rsp_rdata_o   (rsp_rdata),
      .wake_valid_o  (wake_valid),
      .wake_mask_o   (wake_mask),
      .waiters_o     (waiters)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] v, input logic wr);
      if (v == 4 || v == 5) return wr ? "R6/R7" : (m_cnt != 0 ? "R3" : (v == 4 ? "R4" : "R5"));
      if (v == 0) return "R8";
      if (v == 1) return "R10";
      if (v == 2 || v == 3) return "R9";
      return "R11";
   endfunction

   task automatic apply(input logic [3:0] v, input logic wr,
                        input logic [2:0] id, input logic [31:0] wd);
      logic [31:0] e_rd;
      logic        e_blk, e_wv;
      logic [7:0]  e_wm;
      string       t;
      t     = tag_of(v, wr);
      e_rd  = '0;
      e_blk = 1'b0;
      e_wv  = 1'b0;
      e_wm  = '0;
      if (v == 4 || v == 5) begin
         if (wr) begin
            if (m_cnt < 32'hFFFF) m_cnt++;
            e_wv   = (m_wait != 0);
            e_wm   = m_wait;
            m_wait = '0;
         end else if (m_cnt != 0) begin
            e_rd = m_cnt;
            m_cnt--;
         end else if (v == 4) begin
            e_blk     = 1'b1;
            m_wait[id] = 1'b1;
         end
      end else if (v == 0) begin
         if (!wr) e_rd = m_cnt;
      end else if (v == 1) begin
         if (wr) begin
            m_t = wd[16]; m_f = wd[1]; m_e = wd[0];
         end else begin
            e_rd = (32'(m_t) << 16) | (32'(m_f) << 1) | 32'(m_e);
         end
      end
      @(negedge clk);
      req_valid = 1'b1;
      req_view  = v;
      req_write = wr;
      req_id    = id;
      req_wdata = wd;
      @(posedge clk);
      #2;
      req_valid = 1'b0;
      chk("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
      chk(t, "rdata", rsp_rdata, e_rd);
      chk(t, "blocked", 32'(rsp_blocked), 32'(e_blk));
      chk("R7", "wake_valid", 32'(wake_valid), 32'(e_wv));
      chk("R7", "wake_mask", 32'(wake_mask), 32'(e_wm));
      chk(t, "waiters", 32'(waiters), 32'(m_wait));
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk("R1", "rsp_valid", 32'(rsp_valid), 0);
      chk("R1", "wake_valid", 32'(wake_valid), 0);
      chk("R1", "waiters", 32'(waiters), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "rsp_valid after release", 32'(rsp_valid), 0);
      apply(4'd1, 1'b0, 3'd0, 0);          // R1 control word zero
      apply(4'd0, 1'b0, 3'd0, 0);          // R1 count zero
      // R5: try take on zero
      apply(4'd5, 1'b0, 3'd2, 0);
      apply(4'd0, 1'b0, 3'd0, 0);
      // R4: park two requesters
      apply(4'd4, 1'b0, 3'd3, 0);
      apply(4'd4, 1'b0, 3'd5, 0);
      apply(4'd0, 1'b0, 3'd0, 0);
      // R6/R7: give with ignored data wakes both
      apply(4'd5, 1'b1, 3'd0, 32'hDEAD_BEEF);
      apply(4'd0, 1'b0, 3'd0, 0);
      // wake and re-park back to back
      apply(4'd5, 1'b0, 3'd0, 0);          // R3 take the unit
      apply(4'd4, 1'b0, 3'd1, 0);
      apply(4'd4, 1'b0, 3'd2, 0);
      apply(4'd4, 1'b1, 3'd7, 0);          // wakes 1,2
      apply(4'd4, 1'b0, 3'd1, 0);          // served with 1
      apply(4'd4, 1'b0, 3'd2, 0);          // re-parks
      apply(4'd4, 1'b1, 3'd0, 0);
      apply(4'd4, 1'b1, 3'd0, 0);          // no waiters, no pulse
      apply(4'd4, 1'b1, 3'd0, 0);
      // R3: returns pre-decrement value
      apply(4'd4, 1'b0, 3'd6, 0);
      apply(4'd5, 1'b0, 3'd6, 0);
      // R8/R9/R11 ignored writes, observed by raw read
      apply(4'd0, 1'b1, 3'd0, 32'hFFFF_FFFF);
      apply(4'd2, 1'b1, 3'd0, 32'h1234);
      apply(4'd3, 1'b1, 3'd0, 32'h1234);
      apply(4'd2, 1'b0, 3'd0, 0);
      apply(4'd3, 1'b0, 3'd0, 0);
      for (int v = 6; v < 16; v++) begin
         apply(4'(v), 1'b1, 3'd0, 32'hFF);
         apply(4'(v), 1'b0, 3'd0, 0);
      end
      apply(4'd0, 1'b0, 3'd0, 0);
      // R10: control write/read, mode flag stays low
      apply(4'd1, 1'b1, 3'd0, 32'h0003_0003);
      apply(4'd1, 1'b0, 3'd0, 0);
      apply(4'd0, 1'b0, 3'd0, 0);
      apply(4'd1, 1'b1, 3'd0, 32'hFFFE_FFFC);
      apply(4'd1, 1'b0, 3'd0, 0);
      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         logic [3:0]  v;
         r = $urandom % 10;
         if (r < 4)       v = 4'd4;
         else if (r < 7)  v = 4'd5;
         else if (r == 7) v = 4'd0;
         else if (r == 8) v = 4'd1;
         else             v = 4'($urandom);
         apply(v, 1'($urandom), 3'($urandom), $urandom);
      end
      // R6: saturation at 0xFFFF
      for (int i = 0; i < 65540; i++) apply(4'd5, 1'b1, 3'd0, 0);
      apply(4'd0, 1'b0, 3'd0, 0);
      apply(4'd4, 1'b0, 3'd4, 0);
      apply(4'd0, 1'b0, 3'd0, 0);
      summary();
   end

endmodule